// File: doc/BRIEF.md
# Multi-Cycle Register-Indirect Word Processor

This block is a 32-bit processor core that addresses memory in whole words. It has 32 general registers and an instruction pointer. Every operand that reaches memory, and every jump target, is read from a register. The core moves data over one shared internal bus, one transfer per clock state. A finite-state sequencer therefore spends several states on each instruction: a fetch sequence, a decode state, then a short execute path chosen by the opcode.

Instructions and data live in one external memory behind a request/ready port. The core raises `mem_req` and holds the address, the write flag and the write data steady until `mem_rdy` answers. Read data is captured in the cycle in which ready is seen. Memory latency can therefore be anything from one cycle up. Negative addresses are ordinary 32-bit signed word addresses, so a system can decode them for peripherals.

Top module: `wcpu_core`

## Requirements
- R1: Reset clears the instruction pointer and all 32 registers to zero. The first memory request after reset is a read of address 0.
- R2: Each instruction is fetched by a read at the current instruction pointer, which then advances by one. While `mem_req` is high and `mem_rdy` is low, the request, address, write flag and write data stay unchanged. Results do not depend on memory latency.
- R3: Load-immediate is encoded as bits 31:29 = 110, destination register in 28:24 and a 24-bit constant in 23:0. The constant is sign-extended to 32 bits and written to the destination.
- R4: Add-immediate has the same layout with bits 31:29 = 111. It adds the sign-extended constant to the destination register.
- R5: Register forms carry the opcode in 31:24, register fields A in 23:19, B in 18:14 and C in 13:9. Add (0x04), subtract (0x05) and multiply (0x06) write A = B op C, keeping the low 32 bits.
- R6: Divide (0x07) writes the signed quotient of B by C, truncated toward zero, to A. A zero divisor writes all ones.
- R7: And (0x08) and or (0x09) write A = B op C. Complement (0x0A) writes the bitwise inverse of B to A. Copy (0x03) writes B to A.
- R8: Shift-right (0x0B) shifts B arithmetically right by the signed amount in C, and shift-left (0x0C) shifts B left. A negative amount reverses the direction and uses its magnitude. A magnitude of 32 or more gives 0 on a left shift and the sign fill on a right shift.
- R9: Load (0x01) reads the word at the address held in B into A. Store (0x02) writes B to the address held in A.
- R10: The conditional jumps compare B with C as signed values: equal (0x10), not equal (0x11), greater (0x12), greater or equal (0x13), less (0x14), less or equal (0x15). When the condition holds the instruction pointer takes the value of A; otherwise execution falls through.
- R11: Unconditional jump (0x16) loads the instruction pointer from A. Jump-to-subroutine (0x17) writes the address of the following instruction into B and jumps to the value A held before that write, even when A and B name the same register.
- R12: Any other opcode, including 0x00 and 0x80 to 0xBF, changes no register and no memory word, and execution continues at the next word.
- R13: `mem_we` is never high unless `mem_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_req | output | 1 | Memory access request, held until ready |
| mem_we | output | 1 | High for a write, low for a read |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Data for a write |
| mem_rdata | input | 32 | Read data, valid while `mem_rdy` is high |
| mem_rdy | input | 1 | Completion of the current request |

## Verification
The hardest situation to reach from the ports is a jump-to-subroutine whose target and link registers are the same. The link write must not change the target already read. The stimulus loads a small program that issues exactly that instruction and places a marker instruction in the fall-through slot. It then stores both registers back to memory, so the jump destination and the link value become visible as memory words. The wait loops are reached by running the same programs against a memory model with several response latencies, and the stored results must agree.

// File: rtl/wcpu_pkg.sv
package wcpu_pkg;

  localparam int WORD_W = 32;
  localparam int IMM_W  = 24;

  localparam logic [7:0] OP_LOAD  = 8'h01;
  localparam logic [7:0] OP_STORE = 8'h02;
  localparam logic [7:0] OP_COPY  = 8'h03;
  localparam logic [7:0] OP_ADD   = 8'h04;
  localparam logic [7:0] OP_SUB   = 8'h05;
  localparam logic [7:0] OP_MUL   = 8'h06;
  localparam logic [7:0] OP_DIV   = 8'h07;
  localparam logic [7:0] OP_AND   = 8'h08;
  localparam logic [7:0] OP_OR    = 8'h09;
  localparam logic [7:0] OP_COMP  = 8'h0A;
  localparam logic [7:0] OP_SHR   = 8'h0B;
  localparam logic [7:0] OP_SHL   = 8'h0C;
  localparam logic [7:0] OP_JEQ   = 8'h10;
  localparam logic [7:0] OP_JNE   = 8'h11;
  localparam logic [7:0] OP_JGT   = 8'h12;
  localparam logic [7:0] OP_JGE   = 8'h13;
  localparam logic [7:0] OP_JLT   = 8'h14;
  localparam logic [7:0] OP_JLE   = 8'h15;
  localparam logic [7:0] OP_JUNC  = 8'h16;
  localparam logic [7:0] OP_JSUB  = 8'h17;
  // internal codes for the two immediate forms (bits 31:29 = 110 / 111)
  localparam logic [7:0] OP_LIM   = 8'hC0;
  localparam logic [7:0] OP_AIM   = 8'hE0;

  typedef enum logic [4:0] {
    S_FADDR, S_FREAD, S_FINC, S_FIR, S_DEC,
    S_OPA, S_OPB, S_IMMB, S_EXEC, S_WB, S_LIM,
    S_LADDR, S_LREAD, S_LWB,
    S_SADDR, S_SDATA, S_SWRITE,
    S_JTEST, S_JLINK, S_JGO
  } seq_state_e;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_MUL, ALU_DIV, ALU_AND, ALU_OR,
    ALU_NOT, ALU_PASS, ALU_SHR, ALU_SHL
  } alu_op_e;

  typedef enum logic [2:0] {
    BUS_NONE, BUS_IP, BUS_MDR, BUS_REG, BUS_IMM, BUS_RES, BUS_A
  } bus_src_e;

  function automatic logic [WORD_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{(WORD_W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  // shift whose direction flips when the signed amount is negative
  function automatic logic [WORD_W-1:0] shift_signed(input logic [WORD_W-1:0] v,
                                                     input logic [WORD_W-1:0] amt,
                                                     input logic left_dir);
    logic              neg;
    logic              go_left;
    logic [WORD_W-1:0] mag;
    neg     = amt[WORD_W-1];
    mag     = neg ? (~amt + 1'b1) : amt;
    go_left = left_dir ^ neg;
    if (mag >= WORD_W)
      return go_left ? '0 : {WORD_W{v[WORD_W-1]}};
    else if (go_left)
      return v << mag[$clog2(WORD_W)-1:0];
    else
      return WORD_W'($signed(v) >>> mag[$clog2(WORD_W)-1:0]);
  endfunction

  function automatic logic [WORD_W-1:0] div_safe(input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b);
    if (b == '0) return '1;
    return WORD_W'($signed(a) / $signed(b));
  endfunction

  function automatic logic cond_true(input logic [7:0] op,
                                     input logic [WORD_W-1:0] a,
                                     input logic [WORD_W-1:0] b);
    case (op)
      OP_JEQ:  return a == b;
      OP_JNE:  return a != b;
      OP_JGT:  return $signed(a) >  $signed(b);
      OP_JGE:  return $signed(a) >= $signed(b);
      OP_JLT:  return $signed(a) <  $signed(b);
      OP_JLE:  return $signed(a) <= $signed(b);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic is_cond_jump(input logic [7:0] op);
    return (op >= OP_JEQ) && (op <= OP_JLE);
  endfunction

  function automatic logic is_reg_alu(input logic [7:0] op);
    return (op >= OP_COPY) && (op <= OP_SHL);
  endfunction

  function automatic alu_op_e alu_sel(input logic [7:0] op);
    case (op)
      OP_ADD, OP_AIM: return ALU_ADD;
      OP_SUB:         return ALU_SUB;
      OP_MUL:         return ALU_MUL;
      OP_DIV:         return ALU_DIV;
      OP_AND:         return ALU_AND;
      OP_OR:          return ALU_OR;
      OP_COMP:        return ALU_NOT;
      OP_SHR:         return ALU_SHR;
      OP_SHL:         return ALU_SHL;
      default:        return ALU_PASS;
    endcase
  endfunction

endpackage

// File: rtl/wcpu_regfile.sv
module wcpu_regfile #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata = regs[raddr];

endmodule

// File: rtl/wcpu_alu.sv
module wcpu_alu
  import wcpu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_MUL:  y = a * b;
      ALU_DIV:  y = div_safe(a, b);
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_NOT:  y = ~a;
      ALU_SHR:  y = shift_signed(a, b, 1'b0);
      ALU_SHL:  y = shift_signed(a, b, 1'b1);
      default:  y = a;
    endcase
  end

endmodule

// File: rtl/wcpu_core.sv
module wcpu_core
  import wcpu_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int RIDX_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_rdy
);

  seq_state_e st_q, st_d;
  logic [WORD_W-1:0] ip_q, mar_q, mdr_q, ir_q, opa_q, opb_q, res_q;
  logic [WORD_W-1:0] bus, rf_rdata, alu_y;

  // control strobes
  bus_src_e          bus_src;
  logic [RIDX_W-1:0] rf_raddr, rf_waddr;
  logic rf_we, mar_ld, mdr_ld_mem, mdr_ld_bus, ir_ld, a_ld, b_ld, res_ld;
  logic ip_inc, ip_ld, req_c, we_c;

  // instruction fields
  logic              imm_form;
  logic [7:0]        opcode;
  logic [RIDX_W-1:0] ra_f, rb_f, rc_f;
  logic [WORD_W-1:0] imm_ext;

  assign imm_form = (ir_q[31:30] == 2'b11);
  assign opcode   = imm_form ? (ir_q[29] ? OP_AIM : OP_LIM) : ir_q[31:24];
  assign ra_f     = imm_form ? ir_q[28:24] : ir_q[23:19];
  assign rb_f     = ir_q[18:14];
  assign rc_f     = ir_q[13:9];
  assign imm_ext  = sext_imm(ir_q[IMM_W-1:0]);

  // named events for the checker
  logic ev_fetch_read, ev_ip_inc, ev_ip_load;
  assign ev_fetch_read = (st_q == S_FREAD);
  assign ev_ip_inc     = ip_inc;
  assign ev_ip_load    = ip_ld;

  wcpu_regfile #(.DATA_W(WORD_W), .DEPTH(NUM_REGS)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(rf_waddr), .wdata(bus),
    .raddr(rf_raddr), .rdata(rf_rdata)
  );

  wcpu_alu #(.DATA_W(WORD_W)) u_alu (
    .op(alu_sel(opcode)), .a(opa_q), .b(opb_q), .y(alu_y)
  );

  // shared bus
  always_comb begin
    case (bus_src)
      BUS_IP:  bus = ip_q;
      BUS_MDR: bus = mdr_q;
      BUS_REG: bus = rf_rdata;
      BUS_IMM: bus = imm_ext;
      BUS_RES: bus = res_q;
      BUS_A:   bus = opa_q;
      default: bus = '0;
    endcase
  end

  // sequencer
  always_comb begin
    st_d       = st_q;
    bus_src    = BUS_NONE;
    rf_raddr   = rb_f;
    rf_waddr   = ra_f;
    rf_we      = 1'b0;
    mar_ld     = 1'b0;
    mdr_ld_mem = 1'b0;
    mdr_ld_bus = 1'b0;
    ir_ld      = 1'b0;
    a_ld       = 1'b0;
    b_ld       = 1'b0;
    res_ld     = 1'b0;
    ip_inc     = 1'b0;
    ip_ld      = 1'b0;
    req_c      = 1'b0;
    we_c       = 1'b0;
    case (st_q)
      S_FADDR: begin
        bus_src = BUS_IP; mar_ld = 1'b1; st_d = S_FREAD;
      end
      S_FREAD: begin
        req_c = 1'b1;
        if (mem_rdy) begin mdr_ld_mem = 1'b1; st_d = S_FINC; end
      end
      S_FINC: begin
        ip_inc = 1'b1; st_d = S_FIR;
      end
      S_FIR: begin
        bus_src = BUS_MDR; ir_ld = 1'b1; st_d = S_DEC;
      end
      S_DEC: begin
        if (opcode == OP_LIM)                          st_d = S_LIM;
        else if (opcode == OP_AIM || opcode == OP_JSUB) st_d = S_OPA;
        else if (is_reg_alu(opcode) || is_cond_jump(opcode)) st_d = S_OPA;
        else if (opcode == OP_LOAD)                    st_d = S_LADDR;
        else if (opcode == OP_STORE)                   st_d = S_SADDR;
        else if (opcode == OP_JUNC)                    st_d = S_JGO;
        else                                           st_d = S_FADDR;
      end
      S_OPA: begin
        rf_raddr = (opcode == OP_AIM || opcode == OP_JSUB) ? ra_f : rb_f;
        bus_src  = BUS_REG; a_ld = 1'b1;
        if (opcode == OP_AIM)                             st_d = S_IMMB;
        else if (opcode == OP_COPY || opcode == OP_COMP)  st_d = S_EXEC;
        else if (opcode == OP_JSUB)                       st_d = S_JLINK;
        else                                              st_d = S_OPB;
      end
      S_OPB: begin
        rf_raddr = rc_f; bus_src = BUS_REG; b_ld = 1'b1;
        st_d = is_cond_jump(opcode) ? S_JTEST : S_EXEC;
      end
      S_IMMB: begin
        bus_src = BUS_IMM; b_ld = 1'b1; st_d = S_EXEC;
      end
      S_EXEC: begin
        res_ld = 1'b1; st_d = S_WB;
      end
      S_WB: begin
        bus_src = BUS_RES; rf_we = 1'b1; st_d = S_FADDR;
      end
      S_LIM: begin
        bus_src = BUS_IMM; rf_we = 1'b1; st_d = S_FADDR;
      end
      S_LADDR: begin
        rf_raddr = rb_f; bus_src = BUS_REG; mar_ld = 1'b1; st_d = S_LREAD;
      end
      S_LREAD: begin
        req_c = 1'b1;
        if (mem_rdy) begin mdr_ld_mem = 1'b1; st_d = S_LWB; end
      end
      S_LWB: begin
        bus_src = BUS_MDR; rf_we = 1'b1; st_d = S_FADDR;
      end
      S_SADDR: begin
        rf_raddr = ra_f; bus_src = BUS_REG; mar_ld = 1'b1; st_d = S_SDATA;
      end
      S_SDATA: begin
        rf_raddr = rb_f; bus_src = BUS_REG; mdr_ld_bus = 1'b1; st_d = S_SWRITE;
      end
      S_SWRITE: begin
        req_c = 1'b1; we_c = 1'b1;
        if (mem_rdy) st_d = S_FADDR;
      end
      S_JTEST: begin
        st_d = cond_true(opcode, opa_q, opb_q) ? S_JGO : S_FADDR;
      end
      S_JLINK: begin
        bus_src = BUS_IP; rf_waddr = rb_f; rf_we = 1'b1; st_d = S_JGO;
      end
      S_JGO: begin
        rf_raddr = ra_f;
        bus_src  = (opcode == OP_JSUB) ? BUS_A : BUS_REG;
        ip_ld    = 1'b1; st_d = S_FADDR;
      end
      default: st_d = S_FADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= S_FADDR;
      ip_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      opa_q <= '0;
      opb_q <= '0;
      res_q <= '0;
    end else begin
      st_q <= st_d;
      if (ip_inc)          ip_q  <= ip_q + 1'b1;
      else if (ip_ld)      ip_q  <= bus;
      if (mar_ld)          mar_q <= bus;
      if (mdr_ld_mem)      mdr_q <= mem_rdata;
      else if (mdr_ld_bus) mdr_q <= bus;
      if (ir_ld)           ir_q  <= bus;
      if (a_ld)            opa_q <= bus;
      if (b_ld)            opb_q <= bus;
      if (res_ld)          res_q <= alu_y;
    end
  end

  assign mem_req   = req_c;
  assign mem_we    = we_c;
  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;

endmodule

// File: rtl/wcpu_core_checker.sv
module wcpu_core_checker (
  input logic        clk,
  input logic        rst,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_rdy,
  input logic [31:0] ip_q,
  input logic        fetch_read,
  input logic        ip_inc,
  input logic        ip_load
);

  assert_we_with_req_R13: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);

  assert_hold_in_wait_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_we) &&
                               $stable(mem_addr) && $stable(mem_wdata)));

  assert_fetch_at_ip_R2: assert property (@(posedge clk) disable iff (rst)
    fetch_read |-> (mem_req && !mem_we && mem_addr == ip_q));

  assert_ip_step_R2: assert property (@(posedge clk) disable iff (rst)
    ip_inc |=> (ip_q == $past(ip_q) + 32'd1));

  assert_ip_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (!ip_inc && !ip_load) |=> $stable(ip_q));

  assert_ip_cleared_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ip_q == 32'd0 && !mem_req));

endmodule

bind wcpu_core wcpu_core_checker u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdy(mem_rdy),
  .ip_q(ip_q), .fetch_read(ev_fetch_read), .ip_inc(ev_ip_inc),
  .ip_load(ev_ip_load)
);

// File: tb/wcpu_core_tb_top.sv
module wcpu_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DONE_IDX   = 250;

  localparam logic [7:0] C_LOAD = 8'h01, C_STORE = 8'h02, C_COPY = 8'h03,
                         C_ADD = 8'h04, C_SUB = 8'h05, C_MUL = 8'h06,
                         C_DIV = 8'h07, C_AND = 8'h08, C_OR = 8'h09,
                         C_COMP = 8'h0A, C_SHR = 8'h0B, C_SHL = 8'h0C,
                         C_JUNC = 8'h16, C_JSUB = 8'h17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_req, mem_we, mem_rdy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] mem [0:255];
  int          mem_lat = 0;
  int          wait_cnt = 0;
  int          pc = 0;
  int          checks = 0;
  int          errors = 0;
  int          we_viol = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wcpu_core dut_i (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rdy(mem_rdy)
  );

  // memory model with programmable latency
  always @(posedge clk) begin
    if (rst) begin
      mem_rdy  <= 1'b0;
      wait_cnt <= 0;
    end else if (mem_req && !mem_rdy) begin
      if (wait_cnt >= mem_lat) begin
        mem_rdy   <= 1'b1;
        wait_cnt  <= 0;
        mem_rdata <= mem[mem_addr[7:0]];
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end else begin
      mem_rdy <= 1'b0;
    end
  end

  always @(negedge clk) if (!rst && mem_we && !mem_req) we_viol++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // encoders
  function automatic logic [31:0] e_lim(input int r, input logic [31:0] v);
    return {3'b110, r[4:0], v[23:0]};
  endfunction
  function automatic logic [31:0] e_aim(input int r, input logic [31:0] v);
    return {3'b111, r[4:0], v[23:0]};
  endfunction
  function automatic logic [31:0] e_r(input logic [7:0] op, input int a, input int b, input int c);
    return {op, a[4:0], b[4:0], c[4:0], 9'd0};
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    pc = 0;
  endtask
  task automatic emit(input logic [31:0] w);
    mem[pc] = w; pc++;
  endtask
  task automatic put(input int addr, input int r);
    emit(e_lim(31, addr)); emit(e_r(C_STORE, 31, r, 0));
  endtask
  task automatic set32(input int r, input logic [31:0] v);
    emit(e_lim(r, {{16{v[31]}}, v[31:16]}));
    emit(e_lim(27, 32'd16));
    emit(e_r(C_SHL, r, r, 27));
    emit(e_lim(26, {16'd0, v[15:0]}));
    emit(e_r(C_OR, r, r, 26));
  endtask
  task automatic finish_prog();
    emit(e_lim(29, 32'd1));
    put(DONE_IDX, 29);
    emit(e_lim(28, pc + 1));
    emit(e_r(C_JUNC, 28, 0, 0));
  endtask

  task automatic start_prog(input int lat);
    mem_lat = lat;
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask
  task automatic wait_done(input string req);
    bit ok = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (mem[DONE_IDX] == 32'd1) begin ok = 1; break; end
    end
    if (!ok) check({req, " program completion"}, 32'd0, 32'd1);
  endtask
  task automatic run_prog(input int lat, input string req);
    start_prog(lat); wait_done(req);
  endtask

  // independent reference models
  function automatic logic [31:0] ref_shift(input logic [31:0] v, input int amt, input bit left);
    logic [31:0] r = v;
    bit go_left = left;
    int n = amt;
    if (amt < 0) begin go_left = !left; n = -amt; end
    if (n > 32) n = 32;
    for (int i = 0; i < n; i++)
      r = go_left ? {r[30:0], 1'b0} : {r[31], r[31:1]};
    return r;
  endfunction

  // ---- scenarios ----
  task automatic t_reset();
    logic [31:0] a0, a1;
    clear_prog();
    put(200, 5);
    finish_prog();
    mem[200] = 32'hFFFF_FFFF;
    start_prog(0);
    check("R1 no request while in reset", {31'd0, mem_req}, 32'd0);
    while (!mem_req) @(negedge clk);
    a0 = mem_addr;
    check("R1 first request is a read", {31'd0, mem_we}, 32'd0);
    check("R1 first fetch address", a0, 32'd0);
    while (mem_req) @(negedge clk);
    while (!mem_req) @(negedge clk);
    a1 = mem_addr;
    check("R2 second fetch address", a1, 32'd1);
    wait_done("R1");
    check("R1 register cleared by reset", mem[200], 32'd0);
  endtask

  task automatic t_immediate();
    clear_prog();
    emit(e_lim(1, -32'sd5));           put(200, 1);
    emit(e_lim(2, 32'h7FFFFF));        put(201, 2);
    emit(e_aim(2, 32'd1));             put(202, 2);
    emit(e_aim(1, 32'hFF800000));      put(203, 1);
    finish_prog();
    run_prog(1, "R3");
    check("R3 negative immediate sign-extended", mem[200], 32'hFFFF_FFFB);
    check("R3 largest positive immediate", mem[201], 32'h007F_FFFF);
    check("R4 add immediate carry", mem[202], 32'h0080_0000);
    check("R4 add negative immediate", mem[203], 32'hFFFF_FFFB - 32'h0080_0000);
  endtask

  task automatic t_arith();
    logic [31:0] x = 32'h7FFF_FFFF, y = 32'h0001_0003;
    clear_prog();
    set32(1, x); set32(2, y);
    emit(e_r(C_ADD, 3, 1, 2)); emit(e_r(C_SUB, 4, 2, 1)); emit(e_r(C_MUL, 5, 1, 2));
    put(200, 3); put(201, 4); put(202, 5);
    finish_prog();
    run_prog(2, "R5");
    check("R5 add wraps", mem[200], x + y);
    check("R5 subtract", mem[201], y - x);
    check("R5 multiply low word", mem[202], 32'((64'(x) * 64'(y))));
  endtask

  task automatic t_div();
    clear_prog();
    emit(e_lim(1, -32'sd7)); emit(e_lim(2, 32'd2)); emit(e_r(C_DIV, 3, 1, 2));
    emit(e_lim(4, 32'd0));   emit(e_r(C_DIV, 5, 1, 4));
    emit(e_lim(6, 32'd100)); emit(e_lim(7, -32'sd9)); emit(e_r(C_DIV, 8, 6, 7));
    put(200, 3); put(201, 5); put(202, 8);
    finish_prog();
    run_prog(0, "R6");
    check("R6 negative dividend truncates", mem[200], -32'sd3);
    check("R6 divide by zero all ones", mem[201], 32'hFFFF_FFFF);
    check("R6 negative divisor", mem[202], -32'sd11);
  endtask

  task automatic t_logic();
    logic [31:0] x = 32'hF0F0_1234, y = 32'h0FF0_00FF;
    clear_prog();
    set32(1, x); set32(2, y);
    emit(e_r(C_AND, 3, 1, 2)); emit(e_r(C_OR, 4, 1, 2));
    emit(e_r(C_COMP, 5, 1, 0)); emit(e_r(C_COPY, 6, 2, 0));
    put(200, 3); put(201, 4); put(202, 5); put(203, 6);
    finish_prog();
    run_prog(1, "R7");
    check("R7 and", mem[200], x & y);
    check("R7 or", mem[201], x | y);
    check("R7 complement", mem[202], ~x);
    check("R7 copy", mem[203], y);
  endtask

  task automatic t_shift();
    logic [31:0] v = 32'h8000_00F0;
    int amts [4] = '{4, -4, 40, -40};
    clear_prog();
    set32(1, v);
    foreach (amts[i]) begin
      emit(e_lim(2, amts[i]));
      emit(e_r(C_SHR, 3, 1, 2)); put(200 + 2*i, 3);
      emit(e_r(C_SHL, 3, 1, 2)); put(201 + 2*i, 3);
    end
    finish_prog();
    run_prog(0, "R8");
    foreach (amts[i]) begin
      check($sformatf("R8 shr by %0d", amts[i]), mem[200 + 2*i], ref_shift(v, amts[i], 1'b0));
      check($sformatf("R8 shl by %0d", amts[i]), mem[201 + 2*i], ref_shift(v, amts[i], 1'b1));
    end
  endtask

  task automatic t_loadstore(input int lat);
    clear_prog();
    set32(1, 32'hDEAD_BEEF);
    emit(e_lim(2, 32'd210)); emit(e_r(C_STORE, 2, 1, 0));
    emit(e_r(C_LOAD, 3, 2, 0)); put(211, 3);
    emit(e_lim(4, 32'd220)); emit(e_r(C_LOAD, 5, 4, 0)); put(212, 5);
    emit(e_lim(6, -32'sd10)); emit(e_r(C_STORE, 6, 1, 0));
    finish_prog();
    mem[220] = 32'h1234_5678;
    we_viol = 0;
    run_prog(lat, "R9");
    check($sformatf("R9 store via register address (latency %0d)", lat), mem[210], 32'hDEAD_BEEF);
    check($sformatf("R9 load back (latency %0d)", lat), mem[211], 32'hDEAD_BEEF);
    check($sformatf("R2 load of preset word (latency %0d)", lat), mem[212], 32'h1234_5678);
    check("R9 negative address store", mem[246], 32'hDEAD_BEEF);
    check("R13 write only with request", we_viol, 32'd0);
  endtask

  task automatic t_jump_case(input logic [7:0] op, input int b, input int c);
    bit taken;
    case (op)
      8'h10: taken = (b == c);
      8'h11: taken = (b != c);
      8'h12: taken = (b > c);
      8'h13: taken = (b >= c);
      8'h14: taken = (b < c);
      default: taken = (b <= c);
    endcase
    clear_prog();
    emit(e_lim(1, b)); emit(e_lim(2, c)); emit(e_lim(5, 32'd0));
    emit(e_lim(10, 32'd6));
    emit(e_r(op, 10, 1, 2));
    emit(e_lim(5, 32'd1));
    put(200, 5);
    finish_prog();
    run_prog(1, "R10");
    check($sformatf("R10 jump op %h with %0d,%0d", op, b, c), mem[200], taken ? 32'd0 : 32'd1);
  endtask

  task automatic t_jumps();
    int bv [3] = '{3, -2, 5};
    int cv [3] = '{3, 5, -2};
    for (int op = 8'h10; op <= 8'h15; op++)
      for (int k = 0; k < 3; k++) t_jump_case(8'(op), bv[k], cv[k]);
  endtask

  task automatic t_subroutine(input bit same_reg);
    int lreg = same_reg ? 10 : 11;
    clear_prog();
    emit(e_lim(10, 32'd6));
    emit(e_r(C_JSUB, 10, lreg, 0));
    emit(e_lim(12, 32'd99));
    emit(32'd0); emit(32'd0); emit(32'd0);
    put(200, lreg); put(201, 12);
    finish_prog();
    run_prog(2, "R11");
    check($sformatf("R11 link value (same=%0d)", same_reg), mem[200], 32'd2);
    check($sformatf("R11 jump skipped fall-through (same=%0d)", same_reg), mem[201], 32'd0);
  endtask

  task automatic t_undefined();
    clear_prog();
    emit(e_lim(1, 32'd77));
    emit(e_r(8'h00, 1, 1, 1));
    emit(e_r(8'h85, 1, 1, 1));
    emit(e_r(8'h1F, 1, 1, 1));
    emit(e_r(8'h0D, 1, 1, 1));
    put(200, 1);
    finish_prog();
    mem[201] = 32'hA5A5_A5A5;
    run_prog(0, "R12");
    check("R12 undefined opcodes leave register", mem[200], 32'd77);
    check("R12 undefined opcodes leave memory", mem[201], 32'hA5A5_A5A5);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_immediate();
    t_arith();
    t_div();
    t_logic();
    t_shift();
    t_loadstore(0);
    t_loadstore(4);
    t_jumps();
    t_subroutine(1'b0);
    t_subroutine(1'b1);
    t_undefined();
    summary();
    $finish;
  end

endmodule